// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns a serial bit stream into parallel words. It also makes a word clock at one word-width fraction of the serial rate. Every register runs on the serial clock. The serial bit is captured on each rising edge of that clock. After a full group of bits has arrived, the group is presented as one word. The oldest bit of the group sits in the least significant position of the word.

A framer outside the block looks for its alignment pattern in the words. While it has not found that pattern, it raises an alignment request. A request that stays high for at least four serial cycles moves the word boundary by exactly one bit. The block does this by letting one word period run one serial cycle longer than normal. The oldest bit of that stretched period is dropped. The framer repeats the request until the pattern lines up. Each request gives one slip, however long the request stays high.

Top module: `deser_slip`

## Requirements
- R1: Each word holds the last WORD_W serial bits taken in its word period. The bit taken first goes to bit 0 and the bit taken last goes to bit WORD_W-1.
- R2: Without a slip, one word is delivered every WORD_W serial edges. The word clock is high for WORD_W/2 of those edges and low for the rest.
- R3: `par_word` changes only on the serial edge where `word_clk` goes from high to low. Between two such edges it holds its value.
- R4: While `rst` is high at a rising edge, `par_word` is all zeros and `word_clk` is low. The first word, made of the first WORD_W bits after release, appears at the 16th serial edge after release.
- R5: When `align_req` is sampled high on SYNC_MIN consecutive edges, the counter is held at the fifth edge after the first high sample. This holds for SYNC_MIN = 4. The word period that contains that edge lasts WORD_W+1 edges, and its oldest bit is not delivered. This is true for a held edge in the middle of a period and also at either end of a period.
- R6: A request that is sampled high on fewer than SYNC_MIN consecutive edges has no effect on word timing or word contents.
- R7: A request causes only one slip, however long it stays high. A further slip needs at least one low sample and then a new qualifying high run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial bit clock; every register is updated on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data bit, sampled on the rising edge |
| align_req | input | 1 | Active-high request to slip the word boundary by one bit |
| par_word | output | WORD_W | Parallel word; bit 0 is the oldest bit of the group |
| word_clk | output | 1 | Word clock at 1/WORD_W of the serial rate |

## Verification
The bench builds the block with WORD_W = 16 and SYNC_MIN = 4. With these values a word period is short enough to place a slip at three positions: the first edge of a period, its last edge, and the middle. Four-cycle and three-cycle requests can both be tried, which covers the filter threshold from both sides. A 24-cycle request is followed by a short gap and a second request. This shows that one long pulse gives only one slip, and that a later pulse gives a slip of its own.

// File: rtl/deser_pkg.sv
package deser_pkg;
    localparam int unsigned WORD_W_DEF   = 16;
    localparam int unsigned SYNC_MIN_DEF = 4;

    typedef enum logic {
        CLK_LOW  = 1'b0,
        CLK_HIGH = 1'b1
    } half_e;
endpackage

// File: rtl/align_filter.sv
module align_filter
    import deser_pkg::*;
#(
    parameter int unsigned SYNC_MIN = SYNC_MIN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic slip_o
);
    localparam int unsigned RUN_W = $clog2(SYNC_MIN + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(SYNC_MIN);
    localparam logic [RUN_W-1:0] RUN_ARM  = RUN_W'(SYNC_MIN - 1);

    typedef struct packed {
        logic             samp;
        logic [RUN_W-1:0] run;
        logic             fire;
    } flt_t;

    flt_t st_d, st_q;

    // Count consecutive high samples, saturate at the threshold, fire once.
    always_comb begin
        st_d      = st_q;
        st_d.samp = req_i;
        st_d.fire = 1'b0;
        if (!st_q.samp) begin
            st_d.run = '0;
        end else if (st_q.run != RUN_FULL) begin
            st_d.run  = st_q.run + RUN_W'(1);
            st_d.fire = (st_q.run == RUN_ARM);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slip_o = st_q.fire;

    // R7: one slip pulse lasts a single cycle
    p_single_slip_r7: assert property (@(posedge clk) disable iff (rst)
        st_q.fire |=> !st_q.fire);

    // R6: a slip only follows a full run of high samples
    p_slip_after_run_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.fire |-> (st_q.run == RUN_FULL));

    // R7: a slip needs a live high sample in the cycle before
    p_slip_needs_high_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.fire) |-> $past(st_q.samp));
endmodule

// File: rtl/frame_counter.sv
module frame_counter
    import deser_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic slip_i,
    output logic load_o,
    output logic word_clk_o
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(WORD_W / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        half_e            phase;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!slip_i) begin
            if (st_q.cnt == CNT_LAST) st_d.cnt = '0;
            else                      st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.phase = (st_d.cnt >= CNT_HALF) ? CLK_HIGH : CLK_LOW;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{cnt: '0, phase: CLK_LOW};
        else     st_q <= st_d;
    end

    assign load_o     = (st_q.cnt == CNT_LAST) && !slip_i;
    assign word_clk_o = (st_q.phase == CLK_HIGH);

    // R5: a slip freezes the divider for one cycle
    p_hold_on_slip_r5: assert property (@(posedge clk) disable iff (rst)
        slip_i |=> $stable(st_q.cnt));

    // R3: a word load coincides with the falling word clock
    p_load_at_fall_r3: assert property (@(posedge clk) disable iff (rst)
        load_o |=> (st_q.phase == CLK_LOW) && ($past(st_q.phase) == CLK_HIGH));
endmodule

// File: rtl/word_assembler.sv
module word_assembler
    import deser_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_i,
    input  logic              load_i,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] word;
    } asm_t;

    asm_t              st_d, st_q;
    logic [WORD_W-1:0] shift_nx;

    // Newest bit enters at the top, so the oldest ends at bit 0.
    for (genvar i = 0; i < WORD_W; i++) begin : g_shift
        if (i == WORD_W - 1) begin : g_top
            assign shift_nx[i] = bit_i;
        end else begin : g_mid
            assign shift_nx[i] = st_q.shreg[i+1];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.shreg = shift_nx;
        if (load_i) st_d.word = shift_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o = st_q.word;

    // R3: the output word holds between loads
    p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(st_q.word));
endmodule

// File: rtl/deser_slip.sv
module deser_slip
    import deser_pkg::*;
#(
    parameter int unsigned WORD_W   = WORD_W_DEF,
    parameter int unsigned SYNC_MIN = SYNC_MIN_DEF
) (
    input  logic              ser_clk,
    input  logic              rst,
    input  logic              ser_bit,
    input  logic              align_req,
    output logic [WORD_W-1:0] par_word,
    output logic              word_clk
);
    logic slip;
    logic load;

    align_filter #(.SYNC_MIN(SYNC_MIN)) u_filter (
        .clk    (ser_clk),
        .rst    (rst),
        .req_i  (align_req),
        .slip_o (slip)
    );

    frame_counter #(.WORD_W(WORD_W)) u_count (
        .clk        (ser_clk),
        .rst        (rst),
        .slip_i     (slip),
        .load_o     (load),
        .word_clk_o (word_clk)
    );

    word_assembler #(.WORD_W(WORD_W)) u_asm (
        .clk    (ser_clk),
        .rst    (rst),
        .bit_i  (ser_bit),
        .load_i (load),
        .word_o (par_word)
    );

    // R4: outputs are cleared on the first cycle out of reset
    p_reset_clear_r4: assert property (@(posedge ser_clk) disable iff (rst)
        $past(rst) |-> (!word_clk && (par_word == '0)));

    // R3: the word changes only together with a falling word clock
    p_word_on_fall_r3: assert property (@(posedge ser_clk) disable iff (rst)
        !$stable(par_word) |-> $fell(word_clk));
endmodule

// File: tb/sim_deser_slip.sv
`timescale 1ns/1ps
module sim_deser_slip;
    localparam int W = 16;
    localparam int SMIN = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_bit = 1'b0;
    logic         align_req = 1'b0;
    logic [W-1:0] par_word;
    logic         word_clk;

    always #2.5 clk = ~clk;

    deser_slip #(.WORD_W(W), .SYNC_MIN(SMIN)) u0 (
        .ser_clk   (clk),
        .rst       (rst),
        .ser_bit   (ser_bit),
        .align_req (align_req),
        .par_word  (par_word),
        .word_clk  (word_clk)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard queues
    logic [W-1:0] q_word[$];
    int           q_len[$];
    string        q_tag[$];

    // driver-side model state
    int           ec = 0;
    int           run = 0;
    int           hold_edge = -1;
    int           left = W;
    int           plen = 0;
    logic [W-1:0] acc = '0;
    logic [15:0]  lfsr = 16'hACE1;
    string        tag = "R1";

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // drives one bit for the coming edge and updates the expected stream
    task automatic send_bit(input logic b, input logic s);
        ser_bit   = b;
        align_req = s;
        ec++;
        if (s) run++; else run = 0;
        if (run == SMIN) hold_edge = ec + 2;  // fifth edge after first high sample
        if (ec == hold_edge) left++;
        acc = {b, acc[W-1:1]};
        left--;
        plen++;
        if (left == 0) begin
            q_word.push_back(acc);
            q_len.push_back(plen);
            q_tag.push_back(tag);
            left = W;
            plen = 0;
        end
        @(negedge clk);
    endtask

    task automatic send_rand(input int n);
        for (int i = 0; i < n; i++) send_bit(next_rand(), 1'b0);
    endtask

    task automatic pulse(input int width);
        for (int i = 0; i < width; i++) send_bit(next_rand(), 1'b1);
        send_bit(next_rand(), 1'b0);
    endtask

    task automatic align_to(input int l);
        while (left != l) send_bit(next_rand(), 1'b0);
    endtask

    // monitor
    bit           mon_en = 1'b1;
    int           cyc = 0;
    int           hi = 0;
    bit           first = 1'b1;
    bit           stable_ok = 1'b1;
    logic         pclk_prev = 1'b0;
    logic [W-1:0] word_prev = '0;

    always @(posedge clk) begin
        #1;
        if (!rst && mon_en) begin
            cyc++;
            if (pclk_prev && !word_clk) begin
                if (q_word.size() == 0) begin
                    check(1'b0, "R2 unexpected word", int'(par_word), 0);
                end else begin
                    logic [W-1:0] ew;
                    int           el;
                    string        et;
                    ew = q_word.pop_front();
                    el = q_len.pop_front();
                    et = q_tag.pop_front();
                    check(par_word == ew, {et, " word"}, int'(par_word), int'(ew));
                    if (first) check(cyc == 16, "R4 first word edge", cyc, 16);
                    else check(cyc == el, (el == W) ? "R2 period" : "R5 period", cyc, el);
                    if (el == W && !first) check(hi == W / 2, "R2 high time", hi, W / 2);
                    check(stable_ok, "R3 word stable", int'(stable_ok), 1);
                end
                first     = 1'b0;
                cyc       = 0;
                hi        = 0;
                stable_ok = 1'b1;
            end else if (par_word != word_prev) begin
                stable_ok = 1'b0;
            end
            if (word_clk) hi++;
            pclk_prev = word_clk;
            word_prev = par_word;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(par_word == '0, "R4 reset word", int'(par_word), 0);
        check(word_clk == 1'b0, "R4 reset word_clk", int'(word_clk), 0);
        rst = 1'b0;
        // R1: explicit ordering patterns, then random data
        tag = "R1";
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < 15; i++) send_bit(1'b0, 1'b0);
        for (int i = 0; i < 15; i++) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_rand(64);
        // R6: too-short request
        tag = "R6";
        align_to(10);
        pulse(3);
        send_rand(40);
        // R5: slip mid-word, at the last edge and at the first edge of a period
        tag = "R5";
        align_to(12);
        pulse(4);
        send_rand(40);
        align_to(6);
        pulse(4);
        send_rand(40);
        align_to(5);
        pulse(5);
        send_rand(40);
        // R7: long request gives one slip, a fresh one gives another
        tag = "R7";
        align_to(14);
        pulse(24);
        send_rand(3);
        pulse(6);
        send_rand(48);
        align_to(W);
        mon_en = 1'b0;
        check(q_word.size() == 0, "R2 all words delivered", q_word.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule